// File: doc/BRIEF.md
# Power-Fail Write-Protect Controller

This block guards a battery-backed memory against corruption while its supply rises and falls. It receives two supply-monitor flags that have already been digitised and synchronised: one set while the supply sits below the power-fail threshold, one set while it sits below the lower switch-over threshold. From these and the external active-low chip, write and output enables it derives an internal select, a write strobe, an output-drive qualifier (low means the data pins float) and a battery-select line.

Durations are measured in ticks of a slow reference strobe, `ref_tick`, a one-cycle pulse in the fast clock domain. After the supply recovers, access stays locked out for `CER_TICKS` ticks. When the supply fails, an access already open is allowed to finish, but for no longer than `WPT_TICKS` ticks. The battery stays isolated from power-on reset until the supply has been valid once. After that, the battery is chosen whenever the supply is below the switch-over threshold.

Top module: `pfwp_ctrl`

## Requirements
- R1: From power-on reset until `below_pfd` is first seen low, `mem_sel`, `mem_wr` and `dq_oe` are 0 and `bat_on` is 0 (battery isolated) whatever `below_sw` does. Asserting `rst_n` low again restores this state.
- R2: Once the supply has been valid once, `bat_on` (1 = battery) equals the `below_sw` value sampled at the previous clock edge. This holds in every power state.
- R3: When `below_pfd` is seen low, access remains blocked for exactly `CER_TICKS` clock edges at which `ref_tick` is 1. Clock edges without a tick do not advance the lockout.
- R4: If `below_pfd` returns high during the lockout, the block goes to the protected state. The next recovery then restarts the full `CER_TICKS` lockout.
- R5: With valid power and no lockout, `mem_wr` is 1 exactly when `ce_n` and `we_n` are both 0. `dq_oe` is 1 exactly when `ce_n` and `oe_n` are 0 and `we_n` is 1. `mem_sel` follows the inverse of `ce_n`.
- R6: If `below_pfd` is seen high while `ce_n` is 1, the block is protected from the following cycle on.
- R7: If `below_pfd` is seen high while `ce_n` is 0, that access stays selected until `ce_n` goes high. From the cycle after that edge, a new low on `ce_n` selects nothing.
- R8: If that access is still open after `WPT_TICKS` ticks, it is cut off and all outputs except `bat_on` go to 0.
- R9: In the protected and lockout states, `mem_sel`, `mem_wr` and `dq_oe` are 0 for any values of `ce_n`, `we_n` and `oe_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| ref_tick | input | 1 | One-cycle strobe from the slow reference clock |
| below_pfd | input | 1 | Supply below power-fail threshold (synchronised) |
| below_sw | input | 1 | Supply below battery switch-over threshold (synchronised) |
| ce_n | input | 1 | External chip enable, active low |
| we_n | input | 1 | External write enable, active low |
| oe_n | input | 1 | External output enable, active low |
| mem_sel | output | 1 | Internal memory select |
| mem_wr | output | 1 | Qualified write strobe |
| dq_oe | output | 1 | Data-pin drive qualifier; 0 forces high impedance |
| bat_on | output | 1 | 1 selects the internal battery, 0 the external supply |

## Verification
The assertions assume that both supply flags are synchronous to `clk` and change only between edges. They also assume that `below_sw` is never high while `below_pfd` is low, since the switch-over level lies below the power-fail level. The stimulus raises `below_sw` only in cycles where `below_pfd` is already high, and it changes every input half a clock away from the sampling edge. The timing checks depend on `ref_tick` being a single-cycle pulse. The bench holds it constant at 1 or at 0 for whole stretches, so that lockout and drain durations can be counted in edges.

// File: rtl/pfwp_pkg.sv
package pfwp_pkg;
   typedef enum logic [2:0] {
      PS_UNPOWERED = 3'd0,
      PS_LOCKOUT   = 3'd1,
      PS_ONLINE    = 3'd2,
      PS_DRAIN     = 3'd3,
      PS_GUARD     = 3'd4
   } pwr_state_e;
endpackage

// File: rtl/pfwp_tick_timer.sv
module pfwp_tick_timer #(
   parameter int LIMIT = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic tick,
   output logic expire
);
   localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt;

   assign expire = run & tick & (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!run || expire) cnt <= '0;
      else if (tick)           cnt <= cnt + 1'b1;
   end

   // R3
   cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt) < LIMIT);
   // R3
   idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> cnt == '0);
endmodule

// File: rtl/pfwp_seq.sv
module pfwp_seq
   import pfwp_pkg::*;
#(
   parameter int WPT_TICKS = 100,
   parameter int CER_TICKS = 100000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ref_tick,
   input  logic       below_pfd,
   input  logic       ce_n,
   output pwr_state_e state,
   output logic       allow
);
   pwr_state_e nxt;
   logic lock_done, drain_done;

   pfwp_tick_timer #(.LIMIT(CER_TICKS)) u_lock_tmr (
      .clk(clk), .rst_n(rst_n), .run(state == PS_LOCKOUT),
      .tick(ref_tick), .expire(lock_done));

   pfwp_tick_timer #(.LIMIT(WPT_TICKS)) u_drain_tmr (
      .clk(clk), .rst_n(rst_n), .run(state == PS_DRAIN),
      .tick(ref_tick), .expire(drain_done));

   always_comb begin
      nxt = state;
      unique case (state)
         PS_UNPOWERED: if (!below_pfd) nxt = PS_LOCKOUT;
         PS_LOCKOUT: begin
            if (below_pfd)      nxt = PS_GUARD;
            else if (lock_done) nxt = PS_ONLINE;
         end
         PS_ONLINE: if (below_pfd) nxt = ce_n ? PS_GUARD : PS_DRAIN;
         PS_DRAIN:  if (ce_n || drain_done) nxt = PS_GUARD;
         PS_GUARD:  if (!below_pfd) nxt = PS_LOCKOUT;
         default:   nxt = PS_GUARD;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= PS_UNPOWERED;
      else        state <= nxt;
   end

   assign allow = (state == PS_ONLINE) || (state == PS_DRAIN);

   // R3
   online_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_ONLINE && $past(state) != PS_ONLINE) |-> $past(state) == PS_LOCKOUT);
   // R7
   drain_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_ONLINE && below_pfd && !ce_n) |=> state == PS_DRAIN);
   // R6
   idle_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_ONLINE && below_pfd && ce_n) |=> state == PS_GUARD);
   // R8
   drain_cutoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_DRAIN && drain_done) |=> state == PS_GUARD);
   // R4
   lock_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_LOCKOUT && below_pfd) |=> state == PS_GUARD);
endmodule

// File: rtl/pfwp_bat.sv
module pfwp_bat #(
   parameter bit ISOLATE_UNTIL_POWER = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic below_pfd,
   input  logic below_sw,
   output logic powered_once,
   output logic bat_on
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          powered_once <= 1'b0;
      else if (!below_pfd) powered_once <= 1'b1;
   end

   generate
      if (ISOLATE_UNTIL_POWER) begin : g_isolated
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bat_on <= 1'b0;
            else        bat_on <= powered_once & below_sw;
         end
      end else begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bat_on <= 1'b0;
            else        bat_on <= below_sw;
         end
      end
   endgenerate

   // R2
   bat_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bat_on |-> $past(below_sw));
   // R2
   sticky_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
      powered_once |=> powered_once);
endmodule

// File: rtl/pfwp_gate.sv
module pfwp_gate (
   input  logic allow,
   input  logic ce_n,
   input  logic we_n,
   input  logic oe_n,
   output logic mem_sel,
   output logic mem_wr,
   output logic dq_oe
);
   assign mem_sel = allow & ~ce_n;
   assign mem_wr  = mem_sel & ~we_n;
   assign dq_oe   = mem_sel & ~oe_n & we_n;
endmodule

// File: rtl/pfwp_ctrl.sv
module pfwp_ctrl
   import pfwp_pkg::*;
#(
   parameter int WPT_TICKS = 100,
   parameter int CER_TICKS = 100000,
   parameter bit ISOLATE_UNTIL_POWER = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_tick,
   input  logic below_pfd,
   input  logic below_sw,
   input  logic ce_n,
   input  logic we_n,
   input  logic oe_n,
   output logic mem_sel,
   output logic mem_wr,
   output logic dq_oe,
   output logic bat_on
);
   pwr_state_e state;
   logic       allow;
   logic       powered_once;

   initial begin
      assert (WPT_TICKS >= 1) else $error("WPT_TICKS must be at least 1");
      assert (CER_TICKS >= 1) else $error("CER_TICKS must be at least 1");
   end

   pfwp_seq #(.WPT_TICKS(WPT_TICKS), .CER_TICKS(CER_TICKS)) u_seq (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .below_pfd(below_pfd),
      .ce_n(ce_n), .state(state), .allow(allow));

   pfwp_bat #(.ISOLATE_UNTIL_POWER(ISOLATE_UNTIL_POWER)) u_bat (
      .clk(clk), .rst_n(rst_n), .below_pfd(below_pfd), .below_sw(below_sw),
      .powered_once(powered_once), .bat_on(bat_on));

   pfwp_gate u_gate (
      .allow(allow), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .mem_sel(mem_sel), .mem_wr(mem_wr), .dq_oe(dq_oe));

   // R1
   no_sel_before_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_sel |-> powered_once);
   // R9
   quiet_when_guarded_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr || dq_oe) |-> (state == PS_ONLINE || state == PS_DRAIN));
   // R5
   no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_wr && dq_oe));
endmodule

// File: tb/test_pfwp_ctrl.sv
module test_pfwp_ctrl;
   localparam int WPT = 4;
   localparam int CER = 6;
   localparam int NV  = 40;

   // {below_pfd, below_sw, ce_n, we_n, oe_n, sel, wr, dq_oe, bat}
   localparam logic [8:0] VEC [NV] = '{
      9'b11001_0000, 9'b10001_0000, 9'b00001_0000, 9'b00001_0000,
      9'b00010_0000, 9'b00111_0000, 9'b00111_0000, 9'b00001_0000,
      9'b00001_1100, 9'b00010_1010, 9'b00011_1000, 9'b00110_0000,
      9'b10111_0000, 9'b10001_0000, 9'b11010_0001, 9'b10010_0000,
      9'b00111_0000, 9'b00111_0000, 9'b00111_0000, 9'b00111_0000,
      9'b00111_0000, 9'b00001_0000, 9'b00001_1100, 9'b00001_1100,
      9'b10001_1100, 9'b10001_1100, 9'b10111_0000, 9'b10001_0000,
      9'b00111_0000, 9'b00111_0000, 9'b00111_0000, 9'b00111_0000,
      9'b00111_0000, 9'b00010_0000, 9'b00010_1010, 9'b10010_1010,
      9'b10010_1010, 9'b10010_1010, 9'b10010_1010, 9'b10010_0000
   };

   logic clk = 1'b0;
   logic rst_n, ref_tick, below_pfd, below_sw, ce_n, we_n, oe_n;
   logic mem_sel, mem_wr, dq_oe, bat_on;
   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;

   always #5 clk = ~clk;

   pfwp_ctrl #(.WPT_TICKS(WPT), .CER_TICKS(CER)) i_pfwp_ctrl (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .below_pfd(below_pfd),
      .below_sw(below_sw), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .mem_sel(mem_sel), .mem_wr(mem_wr), .dq_oe(dq_oe), .bat_on(bat_on));

   function automatic string req_of(int i);
      if (i < 2)  return "R1";
      if (i < 8)  return "R3";
      if (i < 12) return "R5";
      if (i == 12) return "R6";
      if (i == 13) return "R9";
      if (i < 16) return "R2";
      if (i < 23) return "R3";
      if (i < 28) return "R7";
      if (i < 35) return "R3";
      return "R8";
   endfunction

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic drive(logic pfd, logic sw, logic c, logic w, logic o);
      below_pfd = pfd; below_sw = sw; ce_n = c; we_n = w; oe_n = o;
   endtask

   task automatic chk(string req, logic [3:0] exp);
      logic [3:0] act;
      act = {mem_sel, mem_wr, dq_oe, bat_on};
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s sel/wr/oe/bat actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      rst_n = 1'b0; ref_tick = 1'b1;
      drive(1, 1, 0, 0, 1);
      @(negedge clk);
      step();
      chk("R1", 4'b0000);            // reset state
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4]);
         step();
         chk(req_of(i), VEC[i][3:0]);
      end

      // R4: power dips during the lockout, full lockout restarts
      drive(0, 0, 1, 1, 1);
      step();                        // lockout edge 0
      repeat (3) step();             // ticks 1..3
      drive(1, 0, 0, 0, 1);
      step();
      chk("R4", 4'b0000);
      drive(0, 0, 0, 0, 1);
      step();                        // lockout edge 0 again
      repeat (4) step();
      step();                        // tick 5
      chk("R4", 4'b0000);
      step();                        // tick 6
      chk("R4", 4'b1100);

      // R3: lockout counts reference ticks, not clocks
      drive(1, 0, 1, 1, 1);
      step();
      ref_tick = 1'b0;
      drive(0, 0, 0, 0, 1);
      repeat (10) step();
      chk("R3", 4'b0000);
      ref_tick = 1'b1;
      repeat (5) step();
      chk("R3", 4'b0000);
      step();
      chk("R3", 4'b1100);

      // R9: guarded state ignores a read request
      drive(1, 0, 1, 1, 1);
      step();
      drive(1, 0, 0, 1, 0);
      step();
      chk("R9", 4'b0000);

      // R1 / R2: reset clears the powered-once memory
      rst_n = 1'b0;
      drive(1, 1, 0, 0, 1);
      step();
      chk("R1", 4'b0000);
      rst_n = 1'b1;
      step();
      step();
      chk("R1", 4'b0000);
      drive(0, 0, 1, 1, 1);
      step();
      drive(1, 1, 1, 1, 1);
      step();
      chk("R2", 4'b0001);

      done = 1'b1;
      finish_run();
   end
endmodule